// File: doc/BRIEF.md
# Three-Instruction Hardwired Control Sequencer

This block is the control unit for a very small processor that knows three instructions. Each instruction takes five clock cycles. A one-hot ring of five step flops walks through the steps. A two-bit instruction register holds the operation that is running. Sum-of-products logic combines the step with the decoded instruction and drives eleven register-transfer strobes: load and drive for four general registers, a drive for the program counter, a drive for the arithmetic result, and a completion strobe.

The opcode input is captured in two cases. The first is on every clock edge while reset is held. The second is on the edge that takes the ring from its last step back to its first. Changes to the opcode at any other time have no effect until the running instruction completes. The datapath that the strobes steer, the arithmetic unit and instruction fetch are outside this block.

Top module: `hw_ctl_seq`

## Requirements
- R1: While `rst` is high on a rising edge, the step ring goes to step 1 and the instruction register loads `opcode`. In the first cycle after reset, the outputs show step 1 of that opcode.
- R2: The step advances by one on each rising edge, from step 1 through step 5 and then back to step 1. `seq_done` is high in step 5 for every opcode, and low in all other steps.
- R3: With operation code 2'b00: step 1 raises `ra_load`, `rb_drive` and `rc_load`. Step 2 raises `pc_drive` and `rb_load`. Step 3 raises `z_drive` and `ra_load`. Step 4 raises `rb_load` and `rc_drive`.
- R4: With operation code 2'b01: step 1 raises `rc_load`, `rb_drive` and `rd_load`. Step 2 raises `ra_drive` and `rb_load`. Step 3 raises `z_drive` and `ra_load`. Step 4 raises `rb_load` and `rc_drive`.
- R5: With operation code 2'b10: step 1 raises `rd_load` and `ra_drive`. Step 2 raises `ra_load` and `rb_drive`. Step 3 raises `z_drive` and `ra_load`. Step 4 raises `rd_drive` and `ra_load`.
- R6: `ra_load` equals (step1 AND code 00) OR (step2 AND code 10) OR (step4 AND code 10) OR (step3 AND any legal code).
- R7: The instruction register loads `opcode` only on the edge from step 5 to step 1, or during reset. Changes to `opcode` in the middle of an instruction do not change the strobes of that instruction.
- R8: Code 2'b11 is illegal. While it is latched, every strobe except `seq_done` stays low. The steps still advance, and step 5 still raises `seq_done`.
- R9: A strobe is high only in the step and code combinations listed in R2 to R5, and low in every other combination.
- R10: All strobes are combinational functions of the current step and the latched code, so they are valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 2 | Operation code, captured at the start of each instruction |
| ra_load | output | 1 | Load register A |
| ra_drive | output | 1 | Drive register A onto the bus |
| rb_load | output | 1 | Load register B |
| rb_drive | output | 1 | Drive register B onto the bus |
| rc_load | output | 1 | Load register C |
| rc_drive | output | 1 | Drive register C onto the bus |
| rd_load | output | 1 | Load register D |
| rd_drive | output | 1 | Drive register D onto the bus |
| pc_drive | output | 1 | Drive the program counter onto the bus |
| z_drive | output | 1 | Drive the arithmetic result onto the bus |
| seq_done | output | 1 | Last step of the instruction |

## Verification
The hardest situation to reach from the ports is an opcode that changes in the middle of an instruction while the old code must keep steering the strobes. Getting there means changing `opcode` at an arbitrary step, not only at instruction boundaries. The stimulus therefore draws a new random code on most falling edges. This includes the illegal code, so the illegal path is reached both at a boundary and mid-instruction. Directed phases hold one code for whole instructions and assert reset in the middle of a sequence.

// File: rtl/hw_ctl_pkg.sv
package hw_ctl_pkg;
  localparam int STEPS  = 5;
  localparam int OP_W   = 2;
  localparam int NUM_OP = 3;

  typedef enum logic [OP_W-1:0] {
    OP_FIRST  = 2'b00,
    OP_SECOND = 2'b01,
    OP_THIRD  = 2'b10,
    OP_BAD    = 2'b11
  } op_e;

  typedef struct packed {
    logic ra_load;
    logic ra_drive;
    logic rb_load;
    logic rb_drive;
    logic rc_load;
    logic rc_drive;
    logic rd_load;
    logic rd_drive;
    logic pc_drive;
    logic z_drive;
    logic seq_done;
  } strobe_t;
endpackage

// File: rtl/hw_step_ring.sv
module hw_step_ring #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  output logic [N-1:0] step,
  output logic         wrap
);
  localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

  assign wrap = step[N-1];

  always_ff @(posedge clk) begin
    if (rst) step <= FIRST;
    else     step <= {step[N-2:0], step[N-1]};
  end
endmodule

// File: rtl/hw_instr_reg.sv
module hw_instr_reg
  import hw_ctl_pkg::*;
#(
  parameter int W  = OP_W,
  parameter int NI = NUM_OP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  op_in,
  output logic [W-1:0]  op_q,
  output logic [NI-1:0] op_hot
);
  always_ff @(posedge clk) begin
    if (rst || load) op_q <= op_in;
  end

  // one-hot decode of each legal code; illegal codes give all zeros
  for (genvar i = 0; i < NI; i++) begin : g_dec
    assign op_hot[i] = (op_q == W'(i));
  end
endmodule

// File: rtl/hw_strobe_dec.sv
module hw_strobe_dec
  import hw_ctl_pkg::*;
#(
  parameter int N  = STEPS,
  parameter int NI = NUM_OP
) (
  input  logic [N-1:0]  t,
  input  logic [NI-1:0] i,
  output strobe_t       s
);
  logic legal;
  assign legal = |i;

  always_comb begin
    s.ra_load  = (t[0] & i[0]) | (t[1] & i[2]) | (t[3] & i[2]) | (t[2] & legal);
    s.ra_drive = (t[1] & i[1]) | (t[0] & i[2]);
    s.rb_load  = (t[1] & (i[0] | i[1])) | (t[3] & (i[0] | i[1]));
    s.rb_drive = (t[0] & (i[0] | i[1])) | (t[1] & i[2]);
    s.rc_load  = t[0] & (i[0] | i[1]);
    s.rc_drive = t[3] & (i[0] | i[1]);
    s.rd_load  = t[0] & (i[1] | i[2]);
    s.rd_drive = t[3] & i[2];
    s.pc_drive = t[1] & i[0];
    s.z_drive  = t[2] & legal;
    s.seq_done = t[N-1];
  end
endmodule

// File: rtl/hw_ctl_seq.sv
module hw_ctl_seq
  import hw_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            ra_load,
  output logic            ra_drive,
  output logic            rb_load,
  output logic            rb_drive,
  output logic            rc_load,
  output logic            rc_drive,
  output logic            rd_load,
  output logic            rd_drive,
  output logic            pc_drive,
  output logic            z_drive,
  output logic            seq_done
);
  logic [STEPS-1:0]  step_oh;
  logic              wrap;
  logic [OP_W-1:0]   ir_q;
  logic [NUM_OP-1:0] ir_hot;
  strobe_t           s;

  hw_step_ring #(.N(STEPS)) u_ring (
    .clk(clk), .rst(rst), .step(step_oh), .wrap(wrap)
  );

  hw_instr_reg #(.W(OP_W), .NI(NUM_OP)) u_ir (
    .clk(clk), .rst(rst), .load(wrap), .op_in(opcode),
    .op_q(ir_q), .op_hot(ir_hot)
  );

  hw_strobe_dec #(.N(STEPS), .NI(NUM_OP)) u_dec (
    .t(step_oh), .i(ir_hot), .s(s)
  );

  assign ra_load  = s.ra_load;
  assign ra_drive = s.ra_drive;
  assign rb_load  = s.rb_load;
  assign rb_drive = s.rb_drive;
  assign rc_load  = s.rc_load;
  assign rc_drive = s.rc_drive;
  assign rd_load  = s.rd_load;
  assign rd_drive = s.rd_drive;
  assign pc_drive = s.pc_drive;
  assign z_drive  = s.z_drive;
  assign seq_done = s.seq_done;
endmodule

// File: rtl/hw_ctl_seq_chk.sv
module hw_ctl_seq_chk
  import hw_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  opcode,
  input logic [STEPS-1:0] step,
  input logic [OP_W-1:0]  instr,
  input logic             ra_load,
  input logic             ra_drive,
  input logic             rb_load,
  input logic             rb_drive,
  input logic             rc_load,
  input logic             rc_drive,
  input logic             rd_load,
  input logic             rd_drive,
  input logic             pc_drive,
  input logic             z_drive,
  input logic             seq_done
);
  logic [9:0] others;
  assign others = {ra_load, ra_drive, rb_load, rb_drive, rc_load, rc_drive,
                   rd_load, rd_drive, pc_drive, z_drive};

  // R1
  reset_load_chk: assert property (@(posedge clk)
    rst |=> (step == STEPS'(1)) && (instr == $past(opcode)));

  // R2
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(step) == 1);

  // R2
  done_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> step[0] && !seq_done);

  // R7
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !seq_done |=> $stable(instr));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (instr == 2'b11) |-> (others == '0));

  // R9
  done_alone_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (others == '0));

  // R6
  shared_step3_chk: assert property (@(posedge clk) disable iff (rst)
    (step[2] && instr != 2'b11) |-> (ra_load && z_drive));
endmodule

bind hw_ctl_seq hw_ctl_seq_chk u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .step(step_oh), .instr(ir_q),
  .ra_load(ra_load), .ra_drive(ra_drive), .rb_load(rb_load),
  .rb_drive(rb_drive), .rc_load(rc_load), .rc_drive(rc_drive),
  .rd_load(rd_load), .rd_drive(rd_drive), .pc_drive(pc_drive),
  .z_drive(z_drive), .seq_done(seq_done)
);

// File: tb/hw_ctl_seq_bench.sv
`timescale 1ns/1ps
module hw_ctl_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] opcode = 2'b00;
  logic ra_load, ra_drive, rb_load, rb_drive, rc_load, rc_drive;
  logic rd_load, rd_drive, pc_drive, z_drive, seq_done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hw_ctl_seq u_hw_ctl_seq (
    .clk(clk), .rst(rst), .opcode(opcode),
    .ra_load(ra_load), .ra_drive(ra_drive), .rb_load(rb_load),
    .rb_drive(rb_drive), .rc_load(rc_load), .rc_drive(rc_drive),
    .rd_load(rd_load), .rd_drive(rd_drive), .pc_drive(pc_drive),
    .z_drive(z_drive), .seq_done(seq_done)
  );

  // bit order: ra_load ra_drive rb_load rb_drive rc_load rc_drive
  //            rd_load rd_drive pc_drive z_drive seq_done
  function automatic logic [10:0] expect_lines(int st, logic [1:0] code);
    logic [10:0] v = '0;
    if (st == 5) return 11'b000_0000_0001;
    case (code)
      2'b00: case (st) // R3
        1: v = 11'b1001_1000_000;
        2: v = 11'b0010_0000_100;
        3: v = 11'b1000_0000_010;
        4: v = 11'b0010_0100_000;
        default: v = '0;
      endcase
      2'b01: case (st) // R4
        1: v = 11'b0001_1010_000;
        2: v = 11'b0110_0000_000;
        3: v = 11'b1000_0000_010;
        4: v = 11'b0010_0100_000;
        default: v = '0;
      endcase
      2'b10: case (st) // R5
        1: v = 11'b0100_0010_000;
        2: v = 11'b1001_0000_000;
        3: v = 11'b1000_0000_010;
        4: v = 11'b1000_0001_000;
        default: v = '0;
      endcase
      default: v = '0; // R8
    endcase
    return v;
  endfunction

  function automatic logic expect_ra(int st, logic [1:0] code);
    // R6 equation
    return (st == 1 && code == 2'b00) || (st == 2 && code == 2'b10) ||
           (st == 4 && code == 2'b10) || (st == 3 && code != 2'b11);
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // reference model
  int m_step = 1;
  logic [1:0] m_ir = 2'b00;
  bit first_after_rst = 1'b0;

  always begin
    logic [10:0] got, exp;
    string req;
    @(posedge clk);
    if (rst) begin
      m_step = 1; m_ir = opcode; first_after_rst = 1'b1;
    end else if (m_step == 5) begin
      m_step = 1; m_ir = opcode; first_after_rst = 1'b0;
    end else begin
      m_step = m_step + 1; first_after_rst = 1'b0;
    end
    #1;
    if (!rst) begin
      got = {ra_load, ra_drive, rb_load, rb_drive, rc_load, rc_drive,
             rd_load, rd_drive, pc_drive, z_drive, seq_done};
      exp = expect_lines(m_step, m_ir);
      if (first_after_rst)     req = "R1";
      else if (m_step == 5)    req = "R2";
      else if (m_ir == 2'b11)  req = "R8";
      else if (opcode != m_ir) req = "R7";
      else if (m_ir == 2'b00)  req = "R3";
      else if (m_ir == 2'b01)  req = "R4";
      else                     req = "R5";
      compared++;
      if (got !== exp) begin
        mismatched++;
        $display("FAIL %s step %0d code %b: got %b expected %b", req, m_step, m_ir, got, exp);
      end
      compared++;
      if (ra_load !== expect_ra(m_step, m_ir)) begin
        mismatched++;
        $display("FAIL R6 step %0d code %b: got %b expected %b", m_step, m_ir, ra_load, expect_ra(m_step, m_ir));
      end
      if (got[10:1] != 10'b0 && exp[10:1] == 10'b0) begin
        // R9 and R10: a strobe raised where none is scheduled, in this same cycle
        compared++;
        mismatched++;
        $display("FAIL R9 step %0d code %b: got %b expected %b", m_step, m_ir, got, exp);
      end
    end
  end

  task automatic hold_op(logic [1:0] c, int cycles);
    repeat (cycles) begin
      @(negedge clk);
      opcode = c;
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    opcode = 2'b10;
    @(negedge clk);
    rst = 1'b0;
    // directed: whole instructions with one code held (R3 R4 R5 R8)
    hold_op(2'b10, 10);
    hold_op(2'b00, 10);
    hold_op(2'b01, 10);
    hold_op(2'b11, 10);
    // directed: mid-instruction changes (R7)
    hold_op(2'b00, 2);
    hold_op(2'b11, 1);
    hold_op(2'b10, 1);
    hold_op(2'b01, 6);
    // directed: reset in the middle of a sequence (R1)
    @(negedge clk); rst = 1'b1; opcode = 2'b01;
    @(negedge clk); rst = 1'b0;
    hold_op(2'b01, 7);
    // random stimulus
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if ($urandom_range(3) != 0) opcode = 2'($urandom);
      rst = ($urandom_range(60) == 0);
    end
    @(negedge clk); rst = 1'b0;
    repeat (6) @(negedge clk);
    report();
  end

  initial begin
    #20000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end
endmodule